// File: doc/BRIEF.md
# SPI Flash Transaction Engine

This block lets software run serial-flash commands through a small bank of byte registers. Software loads an opcode, up to three address bytes and up to four data bytes, then writes a control byte. The control byte states the whole shape of the transaction: whether an opcode byte goes out, whether an address goes out, which way the data moves, and how many data bytes there are. The engine drives one single-lane SPI link in mode 0 (clock idles low, input sampled on the rising clock edge, output changed on the falling edge). Software polls the top bit of the control byte until the engine clears it.

Chip select is normally asserted by the engine only while a transaction runs. Software can also pull it low through an override bit in the extended control byte. The select then stays asserted across any number of transactions, so a long flash command such as a page program can be built one byte at a time. A lock bit in the same byte stops any new transaction from starting. The SPI clock is the system clock divided by the parameter `CLK_DIV`, which must be even and at least 2.

Top module: `spi_xact_engine`

## Requirements
- R1: After reset, the control byte (offset 8) reads 0x00 and the extended control byte (offset 9) reads 0x02. The opcode (offset 0), the address bytes (offsets 1..3, which are address bytes 0..2) and the data bytes (offsets 4..7, which are data bytes 0..3) read 0x00. Both chip selects are high and SCLK is low.
- R2: Writing the control byte with bit 7 set, while the engine is idle and unlocked, starts a transaction. Bit 7 then reads 1 until the last byte has been shifted, and reads 0 after that.
- R3: Bytes go out in this order: the opcode (when control bit 4 is 0), then the address (when control bit 3 is 1) as address byte 2, then 1, then 0, then the data bytes. Each byte is sent MSB first. The data count is control bits 2:0, and any value above 4 counts as 4.
- R4: When control bit 5 is 1 (write), data bytes 0 upward are sent. With write set, no address and a count of 0, exactly one byte goes out: the opcode.
- R5: When control bit 5 is 0 (read), MOSI carries 0x00 during the data phase. Bytes sampled on the rising SCLK edge are stored into data byte 0 upward.
- R6: SCLK idles low. While shifting, one SCLK period is `CLK_DIV` system clocks, and the period stays the same across byte boundaries.
- R7: Control bit 6 selects the chip select: 0 selects `spi_cs_n[0]` and 1 selects `spi_cs_n[1]`. With extended bit 1 set to 1, only the selected line goes low, and only while a transaction runs. The other line stays high.
- R8: With extended bit 1 set to 0, the selected chip select stays low while the engine is idle and between transactions. It goes high once that bit is set back to 1.
- R9: While extended bit 3 (lock) is 1, a control write with bit 7 set starts nothing: bit 7 reads 0, SCLK does not toggle and no chip select goes low.
- R10: Writes to any register while a transaction runs are ignored. This covers the opcode, the address bytes, the data bytes and the control byte.
- R11: A transaction with no opcode, no address and a count of 0 (control 0x90) finishes at once. It makes no SCLK edge and asserts no chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset for reads and writes |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| spi_sclk | output | 1 | SPI serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 2 | Active-low chip selects, one per device |

## Verification
The in-line assertions check several rules on every cycle. SCLK never rises outside a transaction. The selected chip select is low whenever the engine is busy, and at most one select is ever low. A transaction never begins while the lock is set. The opcode and address registers hold still during a transfer. Received bytes appear only at the end of a transfer. Other behaviour can only be shown by the bench's scenarios: the exact byte order on MOSI, the data count above 4 counting as 4, read data landing in the right data byte, the SCLK period, a select held low by software across two transactions, and ignored register writes during a busy transfer. The bench checks these against a serial flash model.

// File: rtl/spi_xact_pkg.sv
`timescale 1ns/1ps
package spi_xact_pkg;
  localparam int REG_AW      = 4;
  localparam int ADDR_BYTES  = 3;
  localparam int DATA_BYTES  = 4;
  localparam int MAX_BYTES   = 1 + ADDR_BYTES + DATA_BYTES;
  localparam int IDXW        = $clog2(MAX_BYTES);
  localparam int CNTW        = IDXW + 1;

  // register offsets
  localparam int OFS_CODE = 0;
  localparam int OFS_ADR0 = 1;
  localparam int OFS_DAT0 = 4;
  localparam int OFS_CTRL = 8;
  localparam int OFS_EXT  = 9;

  // control byte: bit 7 execute/done, bits 6..0 are the shape below
  localparam int CB_EXEC = 7;
  // extended control byte
  localparam int EB_SWCS = 1;
  localparam int EB_LOCK = 3;

  typedef struct packed {
    logic       dev;    // bit 6
    logic       wr;     // bit 5
    logic       nocmd;  // bit 4
    logic       adr;    // bit 3
    logic [2:0] cnt;    // bits 2..0
  } shape_t;

  function automatic int data_cnt(shape_t s);
    int c;
    c = int'(s.cnt);
    return (c > DATA_BYTES) ? DATA_BYTES : c;
  endfunction

  function automatic int data_ofs(shape_t s);
    return (s.nocmd ? 0 : 1) + (s.adr ? ADDR_BYTES : 0);
  endfunction
endpackage

// File: rtl/spi_xact_regs.sv
`timescale 1ns/1ps
module spi_xact_regs
  import spi_xact_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic [REG_AW-1:0]      bus_addr,
  input  logic [7:0]             bus_wdata,
  output logic [7:0]             bus_rdata,
  input  logic                   busy,
  input  logic                   rx_valid,
  input  logic [IDXW-1:0]        rx_idx,
  input  logic [7:0]             rx_byte,
  output logic                   start,
  output logic [MAX_BYTES*8-1:0] tx_bytes,
  output logic [CNTW-1:0]        n_bytes,
  output logic                   dev_sel,
  output logic                   cs_hold
);
  logic [7:0]                  code_q, code_d;
  logic [ADDR_BYTES-1:0][7:0]  adr_q, adr_d;
  logic [DATA_BYTES-1:0][7:0]  dat_q, dat_d;
  shape_t                      shape_q, shape_d;
  logic                        swcs_q, swcs_d;
  logic                        lock_q, lock_d;
  logic                        wr_ok;
  logic [MAX_BYTES-1:0][7:0]   tx_arr;

  assign wr_ok = bus_wr && !busy;
  assign start = wr_ok && (int'(bus_addr) == OFS_CTRL) && bus_wdata[CB_EXEC] && !lock_q;

  // next-state
  always_comb begin
    int off_q;
    code_d  = code_q;
    adr_d   = adr_q;
    dat_d   = dat_q;
    shape_d = shape_q;
    swcs_d  = swcs_q;
    lock_d  = lock_q;
    off_q   = data_ofs(shape_q);
    if (wr_ok) begin
      if (int'(bus_addr) == OFS_CODE) code_d = bus_wdata;
      for (int k = 0; k < ADDR_BYTES; k++)
        if (int'(bus_addr) == OFS_ADR0 + k) adr_d[k] = bus_wdata;
      for (int k = 0; k < DATA_BYTES; k++)
        if (int'(bus_addr) == OFS_DAT0 + k) dat_d[k] = bus_wdata;
      if (int'(bus_addr) == OFS_CTRL) shape_d = shape_t'(bus_wdata[6:0]);
      if (int'(bus_addr) == OFS_EXT) begin
        swcs_d = bus_wdata[EB_SWCS];
        lock_d = bus_wdata[EB_LOCK];
      end
    end
    if (rx_valid && !shape_q.wr) begin
      for (int k = 0; k < DATA_BYTES; k++)
        if (int'(rx_idx) == off_q + k) dat_d[k] = rx_byte;
    end
  end

  // transmit byte list, built from the shape that applies at start
  always_comb begin
    int off_a;
    int off_d;
    int cnt;
    off_a = shape_d.nocmd ? 0 : 1;
    off_d = data_ofs(shape_d);
    cnt   = data_cnt(shape_d);
    for (int i = 0; i < MAX_BYTES; i++) begin
      tx_arr[i] = 8'h00;
      if (!shape_d.nocmd && i == 0) tx_arr[i] = code_q;
      for (int k = 0; k < ADDR_BYTES; k++)
        if (shape_d.adr && i == off_a + k) tx_arr[i] = adr_q[ADDR_BYTES-1-k];
      for (int k = 0; k < DATA_BYTES; k++)
        if (shape_d.wr && k < cnt && i == off_d + k) tx_arr[i] = dat_q[k];
    end
    n_bytes = CNTW'(off_d + cnt);
  end
  assign tx_bytes = tx_arr;

  // read-back mux
  always_comb begin
    bus_rdata = 8'h00;
    if (int'(bus_addr) == OFS_CODE) bus_rdata = code_q;
    for (int k = 0; k < ADDR_BYTES; k++)
      if (int'(bus_addr) == OFS_ADR0 + k) bus_rdata = adr_q[k];
    for (int k = 0; k < DATA_BYTES; k++)
      if (int'(bus_addr) == OFS_DAT0 + k) bus_rdata = dat_q[k];
    if (int'(bus_addr) == OFS_CTRL) bus_rdata = {busy, shape_q};
    if (int'(bus_addr) == OFS_EXT)  bus_rdata = {4'h0, lock_q, 1'b0, swcs_q, 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      adr_q   <= '0;
      dat_q   <= '0;
      shape_q <= '0;
      swcs_q  <= 1'b1;
      lock_q  <= 1'b0;
    end else begin
      code_q  <= code_d;
      adr_q   <= adr_d;
      dat_q   <= dat_d;
      shape_q <= shape_d;
      swcs_q  <= swcs_d;
      lock_q  <= lock_d;
    end
  end

  assign dev_sel = shape_q.dev;
  assign cs_hold = !swcs_q;

  // R9: a transfer only begins when the lock was clear
  a_r9_no_start_locked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!lock_q));
  // R10: opcode and address stay frozen while busy
  a_r10_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(code_q) && $stable(adr_q)));
endmodule

// File: rtl/spi_xact_shifter.sv
`timescale 1ns/1ps
module spi_xact_shifter
  import spi_xact_pkg::*;
#(
  parameter int CLK_DIV = 4
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [CNTW-1:0]        n_bytes,
  input  logic [MAX_BYTES*8-1:0] tx_bytes,
  input  logic                   spi_miso,
  output logic                   spi_sclk,
  output logic                   spi_mosi,
  output logic                   busy,
  output logic                   rx_valid,
  output logic [IDXW-1:0]        rx_idx,
  output logic [7:0]             rx_byte
);
  localparam int HALF = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;
  localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;

  typedef enum logic {ST_IDLE, ST_RUN} st_e;

  st_e             st_q, st_d;
  logic [DW-1:0]   div_q, div_d;
  logic            sclk_q, sclk_d;
  logic [2:0]      bit_q, bit_d;
  logic [IDXW-1:0] byte_q, byte_d, last_q, last_d, nxt;
  logic [7:0]      txsh_q, txsh_d, rxsh_q, rxsh_d;
  logic            rxv_q, rxv_d;
  logic [IDXW-1:0] rxi_q, rxi_d;
  logic [7:0]      rxb_q, rxb_d;
  logic            tick;

  assign tick = (div_q == DW'(HALF - 1));
  assign nxt  = byte_q + 1'b1;

  always_comb begin
    st_d   = st_q;
    div_d  = div_q;
    sclk_d = sclk_q;
    bit_d  = bit_q;
    byte_d = byte_q;
    last_d = last_q;
    txsh_d = txsh_q;
    rxsh_d = rxsh_q;
    rxv_d  = 1'b0;
    rxi_d  = rxi_q;
    rxb_d  = rxb_q;
    case (st_q)
      ST_IDLE: begin
        if (start && n_bytes != '0) begin
          st_d   = ST_RUN;
          div_d  = '0;
          sclk_d = 1'b0;
          bit_d  = '0;
          byte_d = '0;
          last_d = IDXW'(n_bytes - CNTW'(1));
          txsh_d = tx_bytes[7:0];
        end
      end
      default: begin
        div_d = tick ? '0 : div_q + 1'b1;
        if (tick) begin
          if (!sclk_q) begin
            sclk_d = 1'b1;
            rxsh_d = {rxsh_q[6:0], spi_miso};
          end else begin
            sclk_d = 1'b0;
            if (bit_q == 3'd7) begin
              rxv_d = 1'b1;
              rxb_d = rxsh_q;
              rxi_d = byte_q;
              if (byte_q == last_q) begin
                st_d   = ST_IDLE;
                txsh_d = 8'h00;
              end else begin
                byte_d = nxt;
                bit_d  = '0;
                txsh_d = tx_bytes[{nxt, 3'b000} +: 8];
              end
            end else begin
              bit_d  = bit_q + 1'b1;
              txsh_d = {txsh_q[6:0], 1'b0};
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      div_q  <= '0;
      sclk_q <= 1'b0;
      bit_q  <= '0;
      byte_q <= '0;
      last_q <= '0;
      txsh_q <= '0;
      rxsh_q <= '0;
      rxv_q  <= 1'b0;
      rxi_q  <= '0;
      rxb_q  <= '0;
    end else begin
      st_q   <= st_d;
      div_q  <= div_d;
      sclk_q <= sclk_d;
      bit_q  <= bit_d;
      byte_q <= byte_d;
      last_q <= last_d;
      txsh_q <= txsh_d;
      rxsh_q <= rxsh_d;
      rxv_q  <= rxv_d;
      rxi_q  <= rxi_d;
      rxb_q  <= rxb_d;
    end
  end

  assign busy     = (st_q == ST_RUN);
  assign spi_sclk = sclk_q;
  assign spi_mosi = txsh_q[7];
  assign rx_valid = rxv_q;
  assign rx_idx   = rxi_q;
  assign rx_byte  = rxb_q;

  // R6: clock idles low outside a transfer
  a_r6_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sclk);
  // R6: a rising clock edge only happens inside a transfer
  a_r6_rise_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> busy);
  // R5: a received byte only follows a busy cycle
  a_r5_rx_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(busy));
endmodule

// File: rtl/spi_xact_cs.sv
`timescale 1ns/1ps
module spi_xact_cs #(
  parameter int NUM_DEV = 2,
  localparam int DSW = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busy,
  input  logic               hold,
  input  logic [DSW-1:0]     dev_sel,
  output logic [NUM_DEV-1:0] cs_n
);
  logic active;
  assign active = busy || hold;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_sel
    assign cs_n[g] = !(active && (dev_sel == DSW'(g)));
  end

  // R7: the selected line is low during every transfer
  a_r7_sel_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n[dev_sel]);
  // R7: never more than one device selected
  a_r7_single_dev: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
endmodule

// File: rtl/spi_xact_engine.sv
`timescale 1ns/1ps
module spi_xact_engine
  import spi_xact_pkg::*;
#(
  parameter int CLK_DIV = 4
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic [1:0] spi_cs_n
);
  logic [1:0]             rst_sync_q;
  logic                   rst_int_n;
  logic                   busy, rx_valid, start, dev_sel, cs_hold;
  logic [IDXW-1:0]        rx_idx;
  logic [7:0]             rx_byte;
  logic [MAX_BYTES*8-1:0] tx_bytes;
  logic [CNTW-1:0]        n_bytes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  spi_xact_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .busy     (busy),
    .rx_valid (rx_valid),
    .rx_idx   (rx_idx),
    .rx_byte  (rx_byte),
    .start    (start),
    .tx_bytes (tx_bytes),
    .n_bytes  (n_bytes),
    .dev_sel  (dev_sel),
    .cs_hold  (cs_hold)
  );

  spi_xact_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start   (start),
    .n_bytes (n_bytes),
    .tx_bytes(tx_bytes),
    .spi_miso(spi_miso),
    .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi),
    .busy    (busy),
    .rx_valid(rx_valid),
    .rx_idx  (rx_idx),
    .rx_byte (rx_byte)
  );

  spi_xact_cs #(.NUM_DEV(2)) u_cs (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .busy   (busy),
    .hold   (cs_hold),
    .dev_sel(dev_sel),
    .cs_n   (spi_cs_n)
  );
endmodule

// File: tb/spi_xact_engine_bench.sv
`timescale 1ns/1ps
module spi_xact_engine_bench;
  localparam int CLK_DIV = 4;
  localparam logic [3:0] A_CODE = 4'd0, A_AD0 = 4'd1, A_AD1 = 4'd2, A_AD2 = 4'd3,
                         A_D0 = 4'd4, A_CTRL = 4'd8, A_EXT = 4'd9;

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [7:0]  code;
    logic [23:0] adr;
    logic [31:0] wdat;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'hAC, 8'h02, 24'h123456, 32'hD3C2B1A0},  // write: op, address, 4 data
    '{8'h8A, 8'h0B, 24'h000102, 32'h00000000},  // read: op, address, 2 data
    '{8'hA0, 8'h06, 24'h000000, 32'h00000000},  // opcode only
    '{8'h97, 8'h00, 24'h000000, 32'h00000000},  // read, count 7 -> 4
    '{8'h81, 8'h05, 24'h000000, 32'h00000000},  // op + 1 read
    '{8'hBA, 8'h00, 24'hABCDEF, 32'h00007788}   // no op, address, 2 written
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       spi_sclk, spi_mosi, spi_miso;
  logic [1:0] spi_cs_n;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  spi_xact_engine #(.CLK_DIV(CLK_DIV)) u_spi_xact_engine (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  // ---------------- serial flash model ----------------
  logic       act;
  int         k_idx = 0, b_idx = 0, log_n = 0;
  logic [7:0] sh_in = 8'h00;
  logic [7:0] log_b [0:1023];
  int         sclk_edges = 0, cs0_falls = 0, cs1_falls = 0;
  realtime    t_prev = 0, t_last = 0;

  function automatic logic [7:0] resp(int k);
    return 8'h3C ^ 8'(k * 37);
  endfunction

  assign act = ~&spi_cs_n;
  assign spi_miso = act ? resp(k_idx)[7 - b_idx] : 1'b0;

  always @(posedge spi_sclk or posedge act) begin
    if (!spi_sclk) begin
      k_idx = 0;
      b_idx = 0;
    end else if (act) begin
      sh_in = {sh_in[6:0], spi_mosi};
      if (b_idx == 7) begin
        log_b[log_n] = sh_in;
        log_n = log_n + 1;
        b_idx = 0;
        k_idx = k_idx + 1;
      end else begin
        b_idx = b_idx + 1;
      end
    end
  end

  always @(posedge spi_sclk) begin
    sclk_edges = sclk_edges + 1;
    t_prev = t_last;
    t_last = $realtime;
  end
  always @(negedge spi_cs_n[0]) cs0_falls = cs0_falls + 1;
  always @(negedge spi_cs_n[1]) cs1_falls = cs1_falls + 1;

  // ---------------- helpers ----------------
  task automatic chk(input string req, input string what, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, a, e);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] d;
    bit done = 0;
    for (int i = 0; i < 4000 && !done; i++) begin
      bus_read(A_CTRL, d);
      if (!d[7]) done = 1;
    end
  endtask

  logic [7:0] exp_b [8];
  int exp_n, exp_d;

  task automatic build_exp(input vec_t v);
    int n;
    exp_n = 0;
    if (!v.ctrl[4]) begin exp_b[exp_n] = v.code; exp_n++; end
    if (v.ctrl[3]) begin
      exp_b[exp_n] = v.adr[23:16]; exp_b[exp_n+1] = v.adr[15:8]; exp_b[exp_n+2] = v.adr[7:0];
      exp_n += 3;
    end
    exp_d = exp_n;
    n = (int'(v.ctrl[2:0]) > 4) ? 4 : int'(v.ctrl[2:0]);
    for (int i = 0; i < n; i++) begin
      exp_b[exp_n] = v.ctrl[5] ? v.wdat[8*i +: 8] : 8'h00;
      exp_n++;
    end
  endtask

  task automatic load_regs(input vec_t v);
    bus_write(A_CODE, v.code);
    bus_write(A_AD0, v.adr[7:0]);
    bus_write(A_AD1, v.adr[15:8]);
    bus_write(A_AD2, v.adr[23:16]);
    for (int i = 0; i < 4; i++) bus_write(A_D0 + 4'(i), v.wdat[8*i +: 8]);
  endtask

  task automatic check_log(input int base, input string req);
    chk(req, "byte count", 32'(log_n - base), 32'(exp_n));
    for (int i = 0; i < exp_n; i++)
      chk(req, $sformatf("mosi byte %0d", i), {24'h0, log_b[base + i]}, {24'h0, exp_b[i]});
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] d;
    int base, e0, c0, c1;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    bus_read(A_CTRL, d); chk("R1", "ctrl reset", {24'h0, d}, 32'h00);
    bus_read(A_EXT, d);  chk("R1", "ext reset", {24'h0, d}, 32'h02);
    bus_read(A_CODE, d); chk("R1", "code reset", {24'h0, d}, 32'h00);
    bus_read(A_AD2, d);  chk("R1", "addr2 reset", {24'h0, d}, 32'h00);
    bus_read(A_D0 + 4'd3, d); chk("R1", "data3 reset", {24'h0, d}, 32'h00);
    chk("R1", "cs reset", {30'h0, spi_cs_n}, 32'h3);
    chk("R1", "sclk reset", {31'h0, spi_sclk}, 32'h0);

    // vector table: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      load_regs(VECS[v]);
      build_exp(VECS[v]);
      base = log_n;
      bus_write(A_CTRL, VECS[v].ctrl);
      bus_read(A_CTRL, d);
      chk("R2", "exec bit while running", {31'h0, d[7]}, 32'h1);
      wait_idle();
      bus_read(A_CTRL, d);
      chk("R2", "exec bit cleared", {31'h0, d[7]}, 32'h0);
      check_log(base, VECS[v].ctrl[5] ? "R4" : "R3");
      if (!VECS[v].ctrl[5]) begin
        for (int i = 0; i < exp_n - exp_d; i++) begin
          bus_read(A_D0 + 4'(i), d);
          chk("R5", $sformatf("read data %0d", i), {24'h0, d}, {24'h0, resp(exp_d + i)});
        end
      end
      chk("R7", "cs released", {30'h0, spi_cs_n}, 32'h3);
      chk("R6", "sclk idle", {31'h0, spi_sclk}, 32'h0);
      if (v == 0) chk("R6", "sclk period ns", 32'(int'(t_last - t_prev)), 32'(CLK_DIV * 5));
    end

    // R10 writes during a transfer are ignored
    load_regs(VECS[0]);
    build_exp(VECS[0]);
    base = log_n;
    bus_write(A_CTRL, 8'hAC);
    bus_write(A_D0, 8'hEE);
    bus_write(A_CODE, 8'h99);
    bus_write(A_CTRL, 8'h81);
    wait_idle();
    check_log(base, "R10");
    bus_read(A_D0, d);   chk("R10", "data0 kept", {24'h0, d}, 32'hA0);
    bus_read(A_CODE, d); chk("R10", "code kept", {24'h0, d}, 32'h02);
    bus_read(A_CTRL, d); chk("R10", "ctrl kept", {24'h0, d}, 32'h2C);

    // R9 lock blocks execution
    bus_write(A_EXT, 8'h0A);
    e0 = sclk_edges; c0 = cs0_falls;
    bus_write(A_CTRL, 8'hA0);
    bus_read(A_CTRL, d); chk("R9", "exec bit locked", {31'h0, d[7]}, 32'h0);
    repeat (60) @(negedge clk);
    chk("R9", "no sclk when locked", 32'(sclk_edges - e0), 32'h0);
    chk("R9", "no cs when locked", 32'(cs0_falls - c0), 32'h0);
    bus_write(A_EXT, 8'h02);

    // R8 software-held chip select spans two transactions
    c0 = cs0_falls;
    bus_write(A_EXT, 8'h00);
    chk("R8", "cs held idle", {30'h0, spi_cs_n}, 32'h2);
    bus_write(A_CODE, 8'h06);
    base = log_n;
    bus_write(A_CTRL, 8'hA0);
    wait_idle();
    chk("R8", "cs held after first", {30'h0, spi_cs_n}, 32'h2);
    bus_write(A_CTRL, 8'h91);
    wait_idle();
    bus_read(A_D0, d);
    chk("R8", "frame continued data", {24'h0, d}, {24'h0, resp(1)});
    chk("R8", "bytes in frame", 32'(log_n - base), 32'h2);
    chk("R8", "single cs fall", 32'(cs0_falls - c0), 32'h1);
    bus_write(A_EXT, 8'h02);
    chk("R8", "cs released by sw", {30'h0, spi_cs_n}, 32'h3);

    // R7 device select
    c0 = cs0_falls; c1 = cs1_falls;
    bus_write(A_CODE, 8'h9F);
    base = log_n;
    bus_write(A_CTRL, 8'hE0);
    wait_idle();
    chk("R7", "dev1 byte", {24'h0, log_b[base]}, 32'h9F);
    chk("R7", "dev0 untouched", 32'(cs0_falls - c0), 32'h0);
    chk("R7", "dev1 selected", 32'(cs1_falls - c1), 32'h1);
    chk("R7", "both released", {30'h0, spi_cs_n}, 32'h3);

    // R11 empty transaction
    e0 = sclk_edges; c0 = cs0_falls;
    bus_write(A_CTRL, 8'h90);
    bus_read(A_CTRL, d); chk("R11", "empty done", {31'h0, d[7]}, 32'h0);
    repeat (20) @(negedge clk);
    chk("R11", "no sclk", 32'(sclk_edges - e0), 32'h0);
    chk("R11", "no cs", 32'(cs0_falls - c0), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL R2 watchdog expired: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule